// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that connects a host to a bank of sixteen 8-bit registers held outside it. SCL and SDA are brought into the system clock through a two-flop synchronizer, which oversamples them. Edge logic then picks out the SCL edges and the START, repeated START and STOP conditions. The block matches a fixed 7-bit device address, takes a register pointer byte, and then moves any number of data bytes in either direction until the master ends the transfer.

Writes leave the block as one-cycle strobes that carry an address and a data byte. Reads are taken from the bank's read data, which is selected by the address output. The pointer steps after every data byte and wraps from 0xF to 0x0. Location 0xD is reserved: it is never written and always reads as zero. A cycle-count watchdog ends any transfer that runs past its time budget. The default budget is 0.5 s at 50 MHz. SDA is driven open-drain through an enable that pulls the line low.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, sda_oe_o is 0, reg_wr_o is 0 and reg_addr_o is 0.
- R2: SDA falling while SCL is high starts a new address phase, whatever the current state. SDA rising while SCL is high returns the block to idle with SDA released.
- R3: The first byte after a START is received MSB first. Bits 7:1 are the device address and bit 0 is the direction (0 write, 1 read). On a match the block drives SDA low for the 9th clock. On a mismatch it never drives SDA until the next START.
- R4: In a write transfer, the byte after the address loads the pointer from its low 4 bits, and the block acknowledges it.
- R5: Every later written byte gives exactly one reg_wr_o pulse, one cycle long, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. The byte is acknowledged.
- R6: The pointer steps by one after every data byte, in writes and in reads, and wraps from 0xF to 0x0.
- R7: In a read, the byte at the pointer is sent MSB first. sda_oe_o changes only while SCL is low.
- R8: If the master acknowledges a read byte (SDA low on the 9th clock), the next byte follows. If it does not, the block keeps SDA released until a START or STOP.
- R9: A write to location 0xD is acknowledged but produces no strobe. A read of 0xD returns 0x00.
- R10: A repeated START with a read address continues from the pointer left by the preceding write phase.
- R11: If more than WDOG_CYCLES clocks pass after a START without a STOP, the block returns to idle with SDA released and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | AW | Register pointer, selects write target and read data |
| reg_wdata_o | output | 8 | Data for the write strobe |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
The assertions check several rules on every cycle. The SDA enable changes only while the synchronized SCL is low. A write strobe lasts one cycle, never points at 0xD and occurs only inside a transfer. START, STOP and a watchdog expiry each leave SDA released. Only the bench's scenarios can show the data path end to end: address matching and rejection, pointer loading, auto-increment across the 0xF wrap, reserved-location masking on reads, continuation after a repeated START, the master-NACK ending, and the bus being ignored after a watchdog abort.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } st_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_rf_wdog.sv
module i2c_rf_wdog #(
  parameter int unsigned LIMIT = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (!run_i || clr_i)   cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && !clr_i && (cnt == CW'(LIMIT));
endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h52,
  parameter int         AW        = 4,
  parameter logic [AW-1:0] RSVD_ADDR = AW'(13)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          abort_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o,
  output logic          busy_o
);
  st_e st;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx, rd_byte;
  logic [AW-1:0] ptr;
  logic          rw, mack;

  assign rd_byte = (ptr == RSVD_ADDR) ? 8'h00 : rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_oe_o <= 1'b0; wr_o <= 1'b0; wdata_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (abort_i) begin
        st <= ST_IDLE; sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st <= ST_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE; sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise_i && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0]; sda_oe_o <= 1'b1; st <= ST_ADDR_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else if (st == ST_PTR) begin
                ptr <= sh[AW-1:0]; sda_oe_o <= 1'b1; st <= ST_PTR_ACK;
              end else begin
                wr_o     <= (ptr != RSVD_ADDR);
                wdata_o  <= sh;
                sda_oe_o <= 1'b1;
                st       <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            if (rw) begin
              tx <= rd_byte; sda_oe_o <= ~rd_byte[7]; st <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0; st <= ST_PTR;
            end
          end
          ST_PTR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0; st <= ST_WR;
          end
          ST_WR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0; ptr <= ptr + 1'b1; st <= ST_WR;
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt == 4'd7) begin
              cnt <= '0; sda_oe_o <= 1'b0; ptr <= ptr + 1'b1; st <= ST_RD_ACK;
            end else begin
              cnt      <= cnt + 1'b1;
              tx       <= {tx[6:0], 1'b0};
              sda_oe_o <= ~tx[6];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) mack <= ~sda_i;
            else if (scl_fall_i) begin
              if (mack) begin
                tx <= rd_byte; sda_oe_o <= ~rd_byte[7]; st <= ST_RD;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_o = ptr;
  assign busy_o = (st != ST_IDLE);
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0]    DEV_ADDR    = 7'h52,
  parameter int            AW          = 4,
  parameter logic [AW-1:0] RSVD_ADDR   = AW'(13),
  parameter int unsigned   WDOG_CYCLES = 25_000_000,
  parameter int            SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          reg_wr_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  input  logic [7:0]    reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, wdog_exp, busy;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rf_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk_i, .rst_ni, .run_i(busy), .clr_i(start_det), .expire_o(wdog_exp)
  );

  i2c_rf_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW), .RSVD_ADDR(RSVD_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .abort_i(wdog_exp), .rdata_i(reg_rdata_i),
    .sda_oe_o, .wr_o(reg_wr_o), .addr_o(reg_addr_o), .wdata_o(reg_wdata_o), .busy_o(busy)
  );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
  parameter int            AW        = 4,
  parameter logic [AW-1:0] RSVD_ADDR = AW'(13)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          wdog_exp,
  input logic          busy,
  input logic          sda_oe_o,
  input logic          reg_wr_o,
  input logic [AW-1:0] reg_addr_o
);
  // R7
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(wdog_exp)) |-> !$past(scl_s));
  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
  // R5
  wr_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> busy);
  // R9
  rsvd_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_addr_o != RSVD_ADDR));
  // R2
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
  // R2
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && !start_det) |=> (!busy && !sda_oe_o));
  // R11
  wdog_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_exp |=> (!busy && !sda_oe_o));
endmodule

bind i2c_regfile_target i2c_rf_chk #(.AW(AW), .RSVD_ADDR(RSVD_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .wdog_exp(wdog_exp), .busy(busy), .sda_oe_o(sda_oe_o),
  .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o)
);

// File: tb/test_i2c_regfile_target.sv
module test_i2c_regfile_target;
  localparam logic [6:0] DEV = 7'h52;
  localparam int unsigned WD = 20000;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;
  logic [7:0] bank [16];
  logic [11:0] wr_q [$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_addr];

  i2c_regfile_target #(.DEV_ADDR(DEV), .WDOG_CYCLES(WD)) i_i2c_regfile_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_wr_o(reg_wr), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      bank[reg_addr] = reg_wdata;
      if (wr_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 actual=%0h expected=none", {reg_addr, reg_wdata});
      end else begin
        chk("R5 strobe", {20'h0, reg_addr, reg_wdata}, {20'h0, wr_q.pop_front()});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic m_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~m_ack);
  endtask

  task automatic set_ptr(input logic [3:0] p);
    logic a;
    bus_start();
    wbyte({DEV, 1'b0}, a); chk("R3 addr ack", a, 1);
    wbyte({4'h0, p}, a);   chk("R4 ptr ack", a, 1);
  endtask

  task automatic wr_data(input logic [7:0] v, input logic [3:0] p, input bit exp_strobe);
    logic a;
    if (exp_strobe) wr_q.push_back({p, v});
    wbyte(v, a); chk(exp_strobe ? "R5 data ack" : "R9 rsvd ack", a, 1);
  endtask

  task automatic rd_seq(input logic [3:0] p, input logic [7:0] e0, input logic [7:0] e1,
                        input logic [7:0] e2, input int n, input string req);
    logic a;
    logic [7:0] v;
    logic [7:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    set_ptr(p);
    bus_start();
    wbyte({DEV, 1'b1}, a); chk("R10 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(v, i != n - 1);
      chk(req, v, ex[i]);
    end
  endtask

  initial begin
    logic a, b;
    for (int i = 0; i < 16; i++) bank[i] = 8'h00;
    bank[13] = 8'h5A;
    tick(5);
    // R1
    chk("R1 oe", sda_oe, 0);
    chk("R1 wr", reg_wr, 0);
    chk("R1 addr", reg_addr, 0);
    rst_n = 1'b1; tick(5);

    // write burst, R4 R5 R6
    set_ptr(4'h3);
    chk("R4 pointer", reg_addr, 4'h3);
    wr_data(8'hA1, 4'h3, 1);
    wr_data(8'hB2, 4'h4, 1);
    wr_data(8'hC3, 4'h5, 1);
    bus_stop();
    chk("R2 stop release", sda_oe, 0);

    // repeated START read, R7 R8 R10
    rd_seq(4'h3, 8'hA1, 8'hB2, 8'hC3, 3, "R7 read data");
    chk("R8 nack release", sda_oe, 0);
    recv_bit(b); chk("R8 bus free after nack", b, 1);
    bus_stop();

    // wrap F->0, R6
    set_ptr(4'hE);
    wr_data(8'h11, 4'hE, 1);
    wr_data(8'h22, 4'hF, 1);
    wr_data(8'h33, 4'h0, 1);
    bus_stop();
    rd_seq(4'hF, 8'h22, 8'h33, 8'h00, 2, "R6 read wrap");
    bus_stop();

    // reserved location, R9
    set_ptr(4'hC);
    wr_data(8'h44, 4'hC, 1);
    wr_data(8'h55, 4'hD, 0);
    wr_data(8'h66, 4'hE, 1);
    bus_stop();
    chk("R9 rsvd untouched", bank[13], 8'h5A);
    rd_seq(4'hC, 8'h44, 8'h00, 8'h66, 3, "R9 read mask");
    bus_stop();

    // address mismatch, R3
    bus_start();
    wbyte({7'h53, 1'b0}, a); chk("R3 mismatch nack", a, 0);
    wbyte(8'h07, a);         chk("R3 ignored after mismatch", a, 0);
    bus_stop();

    // watchdog, R11
    set_ptr(4'h2);
    tick(WD + 500);
    chk("R11 oe after abort", sda_oe, 0);
    wbyte(8'h99, a); chk("R11 ignored after abort", a, 0);
    bus_stop();
    set_ptr(4'h2);
    wr_data(8'h77, 4'h2, 1);
    bus_stop();
    chk("R11 recovered write", bank[2], 8'h77);

    tick(20);
    chk("R5 pending strobes", wr_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule